// File: doc/BRIEF.md
# Reconfigurable 2/4-Point FFT Unit

This block is a purely combinational Fourier transform unit. One control input selects either a two-point or a four-point transform. Both sizes run on the same butterfly datapath. The input is four complex samples with small signed components. The output is four complex frequency bins in natural order.

The four-point transform is a radix-2 decimation-in-frequency structure. The first stage adds and subtracts samples that lie half a frame apart. It then rotates each difference by a twiddle coefficient. The second stage butterflies the sums and the rotated differences.

In two-point mode the upper two samples are masked to zero. The first stage then passes samples 0 and 1 unchanged, and the sum/difference butterfly of stage two forms the two-point result. The unused upper bins are forced to zero.

Every twiddle product goes through a small unsigned column-wise (vertical and crosswise) multiplier. A sign wrapper sits around it. The wrapper takes magnitudes, multiplies them and negates the result when the operand signs differ. Only the first half of the twiddle set is stored. Twiddle indices wrap modulo the frame length, and the upper half is produced by negation.

Top module: `fft24_recfg`

## Requirements
- R1: With `mode_4pt` = 0, outputs bin 2 and bin 3 (real and imaginary) are zero for every input.
- R2: With `mode_4pt` = 0, bin 0 equals x0 + x1 and bin 1 equals x0 − x1, for the real and imaginary parts separately.
- R3: With `mode_4pt` = 1, bin 0 equals x0 + x1 + x2 + x3.
- R4: With `mode_4pt` = 1, bin 2 equals x0 − x1 + x2 − x3.
- R5: With `mode_4pt` = 1, bin 1 equals (x0 − x2) − j(x1 − x3). Real part: (xr0 − xr2) + (xi1 − xi3). Imaginary part: (xi0 − xi2) − (xr1 − xr3).
- R6: With `mode_4pt` = 1, bin 3 equals (x0 − x2) + j(x1 − x3). Real part: (xr0 − xr2) − (xi1 − xi3). Imaginary part: (xi0 − xi2) + (xr1 − xr3).
- R7: In two-point mode, samples x2 and x3 have no effect on any output.
- R8: Inputs are W-bit two's complement (default 4). Outputs are W+3-bit two's complement (default 7). No output wraps, including when every input component is −8 or +7.
- R9: Twiddle products keep the correct sign for every combination of operand signs, including the most negative input value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_4pt | input | 1 | 1 = four-point transform, 0 = two-point transform |
| xr0 | input | W | Sample 0 real part, signed |
| xi0 | input | W | Sample 0 imaginary part, signed |
| xr1 | input | W | Sample 1 real part, signed |
| xi1 | input | W | Sample 1 imaginary part, signed |
| xr2 | input | W | Sample 2 real part, signed |
| xi2 | input | W | Sample 2 imaginary part, signed |
| xr3 | input | W | Sample 3 real part, signed |
| xi3 | input | W | Sample 3 imaginary part, signed |
| yr0 | output | W+3 | Bin 0 real part, signed |
| yi0 | output | W+3 | Bin 0 imaginary part, signed |
| yr1 | output | W+3 | Bin 1 real part, signed |
| yi1 | output | W+3 | Bin 1 imaginary part, signed |
| yr2 | output | W+3 | Bin 2 real part, signed |
| yi2 | output | W+3 | Bin 2 imaginary part, signed |
| yr3 | output | W+3 | Bin 3 real part, signed |
| yi3 | output | W+3 | Bin 3 imaginary part, signed |

## Verification
The checker assumes that inputs change only between evaluations and that all inputs carry known values. Its comparisons are then meaningful each time the block's combinational outputs settle. The bench drives every input on one clock edge and compares the outputs half a period later, so each input set has settled before it is checked. The stimulus uses only the legal signed range −8 to +7. It covers all-extreme patterns, impulses, sign sweeps and seeded random frames in both modes. Those vectors exercise the most negative magnitude path without leaving the range the checker assumes.

// File: rtl/fft24_pkg.sv
package fft24_pkg;

   // Twiddle coefficient: signed 2-bit real and imaginary parts
   typedef struct packed {
      logic signed [1:0] re;
      logic signed [1:0] im;
   } twc_t;

   localparam int unsigned FRAME   = 4;
   localparam int unsigned HALF_FR = FRAME / 2;

   // Only the first half of the twiddle set is stored; the index wraps
   // modulo the frame and the upper half is the negated lower half.
   function automatic twc_t twiddle4(input int unsigned k);
      int unsigned kk;
      twc_t        t;
      kk = k % FRAME;
      case (kk % HALF_FR)
         0:       begin t.re = 2'sd1; t.im = 2'sd0;  end
         default: begin t.re = 2'sd0; t.im = -2'sd1; end
      endcase
      if (kk >= HALF_FR) begin
         t.re = -t.re;
         t.im = -t.im;
      end
      return t;
   endfunction

endpackage

// File: rtl/xw_mult_u.sv
// Unsigned column-wise multiplier: each result column sums its crosswise
// bit products plus the carry from the previous column.
module xw_mult_u #(
   parameter int N = 5
) (
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic [2*N-1:0] p
);
   localparam int NCOL = 2 * N - 1;
   localparam int CW   = $clog2(2 * N) + 2;

   if (N < 1) begin : g_bad_n
      $error("xw_mult_u: N must be at least 1");
   end

   logic [NCOL-1:0][N-1:0] pp;

   for (genvar k = 0; k < NCOL; k++) begin : g_col
      for (genvar i = 0; i < N; i++) begin : g_bit
         if ((k - i >= 0) && (k - i < N)) begin : g_on
            assign pp[k][i] = a[i] & b[k-i];
         end else begin : g_off
            assign pp[k][i] = 1'b0;
         end
      end
   end

   always_comb begin
      logic [CW-1:0] carry;
      logic [CW-1:0] s;
      carry = '0;
      p     = '0;
      for (int k = 0; k < NCOL; k++) begin
         s     = carry + CW'($countones(pp[k]));
         p[k]  = s[0];
         carry = s >> 1;
      end
      p[2*N-1] = carry[0];
   end
endmodule

// File: rtl/sgn_mult.sv
// Signed wrapper: magnitudes into the unsigned core, negate on sign mismatch.
module sgn_mult #(
   parameter int AW = 5,
   parameter int BW = 2
) (
   input  logic signed [AW-1:0]    a,
   input  logic signed [BW-1:0]    b,
   output logic signed [AW+BW-1:0] p
);
   localparam int MW = (AW > BW) ? AW : BW;
   localparam int PW = AW + BW;

   if (AW < 2 || BW < 2) begin : g_bad_w
      $error("sgn_mult: operand widths must be at least 2");
   end

   logic [AW-1:0]   mag_a;
   logic [BW-1:0]   mag_b;
   logic [2*MW-1:0] uprod;
   logic [PW-1:0]   uprod_t;
   logic            neg;

   assign mag_a   = a[AW-1] ? (~a + 1'b1) : a;
   assign mag_b   = b[BW-1] ? (~b + 1'b1) : b;
   assign neg     = a[AW-1] ^ b[BW-1];

   xw_mult_u #(.N(MW)) u_core (
      .a (MW'(mag_a)),
      .b (MW'(mag_b)),
      .p (uprod)
   );

   assign uprod_t = uprod[PW-1:0];
   assign p       = neg ? -$signed(uprod_t) : $signed(uprod_t);
endmodule

// File: rtl/twiddle_rot.sv
// Complex rotation of a stage-one difference by a twiddle coefficient.
module twiddle_rot
   import fft24_pkg::*;
#(
   parameter int DW = 5
) (
   input  logic signed [DW-1:0] dr,
   input  logic signed [DW-1:0] di,
   input  twc_t                 c,
   output logic signed [DW:0]   tr,
   output logic signed [DW:0]   ti
);
   localparam int PW = DW + 2;

   logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;

   sgn_mult #(.AW(DW), .BW(2)) u_rr (.a(dr), .b(c.re), .p(p_rr));
   sgn_mult #(.AW(DW), .BW(2)) u_ii (.a(di), .b(c.im), .p(p_ii));
   sgn_mult #(.AW(DW), .BW(2)) u_ri (.a(dr), .b(c.im), .p(p_ri));
   sgn_mult #(.AW(DW), .BW(2)) u_ir (.a(di), .b(c.re), .p(p_ir));

   logic signed [PW:0] sum_r, sum_i;
   assign sum_r = PW'(p_rr) - PW'(p_ii);
   assign sum_i = PW'(p_ri) + PW'(p_ir);

   // Coefficient magnitude never exceeds one, so DW+1 bits hold the result.
   assign tr = sum_r[DW:0];
   assign ti = sum_i[DW:0];
endmodule

// File: rtl/fft24_recfg.sv
module fft24_recfg
   import fft24_pkg::*;
#(
   parameter int W = 4
) (
   input  logic                mode_4pt,
   input  logic signed [W-1:0] xr0,
   input  logic signed [W-1:0] xi0,
   input  logic signed [W-1:0] xr1,
   input  logic signed [W-1:0] xi1,
   input  logic signed [W-1:0] xr2,
   input  logic signed [W-1:0] xi2,
   input  logic signed [W-1:0] xr3,
   input  logic signed [W-1:0] xi3,
   output logic signed [W+2:0] yr0,
   output logic signed [W+2:0] yi0,
   output logic signed [W+2:0] yr1,
   output logic signed [W+2:0] yi1,
   output logic signed [W+2:0] yr2,
   output logic signed [W+2:0] yi2,
   output logic signed [W+2:0] yr3,
   output logic signed [W+2:0] yi3
);
   localparam int SW = W + 1;   // stage-one width
   localparam int TW = W + 2;   // rotated difference width
   localparam int OW = W + 3;   // output width
   localparam int NB = HALF_FR; // butterflies per stage

   if (W < 2 || W > 16) begin : g_bad_w
      $error("fft24_recfg: W must lie in 2..16");
   end

   // Inputs as arrays; upper half masked in two-point mode
   logic signed [W-1:0] in_r [FRAME];
   logic signed [W-1:0] in_i [FRAME];

   always_comb begin
      in_r[0] = xr0; in_i[0] = xi0;
      in_r[1] = xr1; in_i[1] = xi1;
      in_r[2] = mode_4pt ? xr2 : '0;
      in_i[2] = mode_4pt ? xi2 : '0;
      in_r[3] = mode_4pt ? xr3 : '0;
      in_i[3] = mode_4pt ? xi3 : '0;
   end

   // Stage one: sums and rotated differences
   logic signed [SW-1:0] a_r [NB];
   logic signed [SW-1:0] a_i [NB];
   logic signed [SW-1:0] d_r [NB];
   logic signed [SW-1:0] d_i [NB];
   logic signed [TW-1:0] t_r [NB];
   logic signed [TW-1:0] t_i [NB];

   for (genvar n = 0; n < NB; n++) begin : g_s1
      assign a_r[n] = SW'(in_r[n]) + SW'(in_r[n+NB]);
      assign a_i[n] = SW'(in_i[n]) + SW'(in_i[n+NB]);
      assign d_r[n] = SW'(in_r[n]) - SW'(in_r[n+NB]);
      assign d_i[n] = SW'(in_i[n]) - SW'(in_i[n+NB]);

      twiddle_rot #(.DW(SW)) u_rot (
         .dr (d_r[n]),
         .di (d_i[n]),
         .c  (twiddle4(n)),
         .tr (t_r[n]),
         .ti (t_i[n])
      );
   end

   // Stage two: results come out in bit-reversed order (0, 2, 1, 3)
   logic signed [OW-1:0] br_r [FRAME];
   logic signed [OW-1:0] br_i [FRAME];

   assign br_r[0] = OW'(a_r[0]) + OW'(a_r[1]);
   assign br_i[0] = OW'(a_i[0]) + OW'(a_i[1]);
   assign br_r[1] = OW'(a_r[0]) - OW'(a_r[1]);
   assign br_i[1] = OW'(a_i[0]) - OW'(a_i[1]);
   assign br_r[2] = OW'(t_r[0]) + OW'(t_r[1]);
   assign br_i[2] = OW'(t_i[0]) + OW'(t_i[1]);
   assign br_r[3] = OW'(t_r[0]) - OW'(t_r[1]);
   assign br_i[3] = OW'(t_i[0]) - OW'(t_i[1]);

   // Reorder to natural order; in two-point mode bin 1 is the sum/difference
   // butterfly output and the upper bins are zero.
   always_comb begin
      yr0 = br_r[0];
      yi0 = br_i[0];
      if (mode_4pt) begin
         yr1 = br_r[2]; yi1 = br_i[2];
         yr2 = br_r[1]; yi2 = br_i[1];
         yr3 = br_r[3]; yi3 = br_i[3];
      end else begin
         yr1 = br_r[1]; yi1 = br_i[1];
         yr2 = '0;      yi2 = '0;
         yr3 = '0;      yi3 = '0;
      end
   end
endmodule

// File: rtl/fft24_chk.sv
module fft24_chk #(
   parameter int W = 4
) (
   input logic                mode_4pt,
   input logic signed [W-1:0] xr0, xi0, xr1, xi1, xr2, xi2, xr3, xi3,
   input logic signed [W+2:0] yr0, yi0, yr1, yi1, yr2, yi2, yr3, yi3
);
   always_comb begin
      int r0, i0, r1, i1, r2, i2, r3, i3;
      r0 = int'(xr0); i0 = int'(xi0); r1 = int'(xr1); i1 = int'(xi1);
      r2 = int'(xr2); i2 = int'(xi2); r3 = int'(xr3); i3 = int'(xi3);
      if (!mode_4pt) begin
         AST_UPPER_ZERO: assert (yr2 == 0 && yi2 == 0 && yr3 == 0 && yi3 == 0); // R1
         AST_TWO_PT_BINS: assert (int'(yr0) == r0 + r1 && int'(yi0) == i0 + i1
                                 && int'(yr1) == r0 - r1 && int'(yi1) == i0 - i1); // R2
      end else begin
         AST_DC_BIN: assert (int'(yr0) == r0 + r1 + r2 + r3
                             && int'(yi0) == i0 + i1 + i2 + i3); // R3
         AST_NYQ_BIN: assert (int'(yr2) == r0 - r1 + r2 - r3
                              && int'(yi2) == i0 - i1 + i2 - i3); // R4
         AST_BIN_ONE: assert (int'(yr1) == (r0 - r2) + (i1 - i3)
                              && int'(yi1) == (i0 - i2) - (r1 - r3)); // R5
         AST_BIN_THREE: assert (int'(yr3) == (r0 - r2) - (i1 - i3)
                                && int'(yi3) == (i0 - i2) + (r1 - r3)); // R6
      end
   end
endmodule

bind fft24_recfg fft24_chk #(.W(W)) u_chk (
   .mode_4pt (mode_4pt),
   .xr0 (xr0), .xi0 (xi0), .xr1 (xr1), .xi1 (xi1),
   .xr2 (xr2), .xi2 (xi2), .xr3 (xr3), .xi3 (xi3),
   .yr0 (yr0), .yi0 (yi0), .yr1 (yr1), .yi1 (yi1),
   .yr2 (yr2), .yi2 (yi2), .yr3 (yr3), .yi3 (yi3)
);

// File: tb/tb_fft24_recfg.sv
module tb_fft24_recfg;
   localparam int W          = 4;
   localparam int OW         = W + 3;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic                 mode_4pt;
   logic signed [W-1:0]  xr0, xi0, xr1, xi1, xr2, xi2, xr3, xi3;
   logic signed [OW-1:0] yr0, yi0, yr1, yi1, yr2, yi2, yr3, yi3;

   fft24_recfg #(.W(W)) dut (
      .mode_4pt (mode_4pt),
      .xr0 (xr0), .xi0 (xi0), .xr1 (xr1), .xi1 (xi1),
      .xr2 (xr2), .xi2 (xi2), .xr3 (xr3), .xi3 (xi3),
      .yr0 (yr0), .yi0 (yi0), .yr1 (yr1), .yi1 (yi1),
      .yr2 (yr2), .yi2 (yi2), .yr3 (yr3), .yi3 (yi3)
   );

   int n_vec  = 0;
   int n_fail = 0;
   int vr [4];
   int vi [4];

   function automatic int rnd4();
      return int'($urandom_range(15)) - 8;
   endfunction

   // Drive a frame on a rising edge, compare at the following falling edge
   task automatic apply(input logic m, input string tag);
      int er [4];
      int ei [4];
      int ar [4];
      int ai [4];
      int np;
      @(posedge clk);
      mode_4pt = m;
      xr0 = W'(vr[0]); xi0 = W'(vi[0]); xr1 = W'(vr[1]); xi1 = W'(vi[1]);
      xr2 = W'(vr[2]); xi2 = W'(vi[2]); xr3 = W'(vr[3]); xi3 = W'(vi[3]);
      @(negedge clk);
      np = m ? 4 : 2;
      for (int k = 0; k < 4; k++) begin
         er[k] = 0; ei[k] = 0;
         if (k < np) begin
            for (int n = 0; n < np; n++) begin
               int step;
               step = (n * k) % np;
               if (np == 2) begin
                  er[k] += (step == 0) ? vr[n] : -vr[n];
                  ei[k] += (step == 0) ? vi[n] : -vi[n];
               end else begin
                  case (step)
                     0: begin er[k] += vr[n];  ei[k] += vi[n];  end
                     1: begin er[k] += vi[n];  ei[k] -= vr[n];  end
                     2: begin er[k] -= vr[n];  ei[k] -= vi[n];  end
                     default: begin er[k] -= vi[n]; ei[k] += vr[n]; end
                  endcase
               end
            end
         end
      end
      ar[0] = int'(yr0); ai[0] = int'(yi0); ar[1] = int'(yr1); ai[1] = int'(yi1);
      ar[2] = int'(yr2); ai[2] = int'(yi2); ar[3] = int'(yr3); ai[3] = int'(yi3);
      n_vec++;
      begin
         bit bad;
         bad = 1'b0;
         for (int k = 0; k < 4; k++) begin
            if (ar[k] != er[k] || ai[k] != ei[k]) begin
               $display("FAIL %s bin%0d: actual (%0d,%0d) expected (%0d,%0d)",
                        tag, k, ar[k], ai[k], er[k], ei[k]);
               bad = 1'b1;
            end
         end
         if (bad) n_fail++;
      end
   endtask

   task automatic set_all(input int r, input int i);
      for (int n = 0; n < 4; n++) begin vr[n] = r; vi[n] = i; end
   endtask

   task automatic t_zero();
      set_all(0, 0);
      apply(1'b1, "R3 zero frame 4pt");
      apply(1'b0, "R1 zero frame 2pt");
   endtask

   task automatic t_impulse();
      for (int p = 0; p < 4; p++) begin
         set_all(0, 0);
         vr[p] = 3; vi[p] = -2;
         apply(1'b1, "R5 R6 impulse 4pt");
      end
      set_all(0, 0); vr[1] = 5;
      apply(1'b0, "R2 impulse 2pt");
   endtask

   task automatic t_extremes();
      set_all(-8, -8); apply(1'b1, "R8 all -8 4pt");
      set_all(7, 7);   apply(1'b1, "R8 all +7 4pt");
      set_all(-8, -8); apply(1'b0, "R8 all -8 2pt");
      vr = '{7, -8, 7, -8}; vi = '{-8, 7, -8, 7};
      apply(1'b1, "R4 R8 alternating 4pt");
      vr = '{-8, 7, -8, 7}; vi = '{7, 7, -8, -8};
      apply(1'b1, "R9 R8 mixed extremes 4pt");
   endtask

   task automatic t_sign_sweep();
      int vals [4] = '{-8, -1, 1, 7};
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            set_all(0, 0);
            vr[1] = vals[a]; vi[1] = vals[b];
            vr[3] = vals[b]; vi[3] = vals[a];
            apply(1'b1, "R9 twiddle sign sweep");
         end
      end
   endtask

   task automatic t_two_pt_ignore();
      for (int t = 0; t < 20; t++) begin
         vr[0] = rnd4(); vi[0] = rnd4(); vr[1] = rnd4(); vi[1] = rnd4();
         vr[2] = 0; vi[2] = 0; vr[3] = 0; vi[3] = 0;
         apply(1'b0, "R7 baseline 2pt");
         vr[2] = rnd4(); vi[2] = -8; vr[3] = 7; vi[3] = rnd4();
         apply(1'b0, "R7 upper samples ignored 2pt");
      end
   endtask

   task automatic t_random(input logic m, input int cnt);
      for (int t = 0; t < cnt; t++) begin
         for (int n = 0; n < 4; n++) begin vr[n] = rnd4(); vi[n] = rnd4(); end
         apply(m, m ? "R3 R4 R5 R6 random 4pt" : "R1 R2 random 2pt");
      end
   endtask

   initial begin
      mode_4pt = 1'b0;
      {xr0, xi0, xr1, xi1, xr2, xi2, xr3, xi3} = '0;
      void'($urandom(32'd7));
      repeat (2) @(posedge clk);
      t_zero();
      t_impulse();
      t_extremes();
      t_sign_sweep();
      t_two_pt_ignore();
      t_random(1'b1, 400);
      t_random(1'b0, 400);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule